// File: doc/BRIEF.md
# Polled SPI Master with Register Interface

This block is a byte-wide SPI master that software controls through four 32-bit registers on a simple request/write-enable bus. Each write to the transmit register starts a single 8-bit exchange. The byte goes out on MOSI most significant bit first, and a byte is shifted in from MISO at the same time. Software watches a ready bit in the control register to see when the exchange has finished. It then reads the received byte from the receive register.

The serial clock is made by dividing the system clock by a value taken from a five-bit prescaler code. Codes 1 to 15 divide linearly. Codes with bit 4 set select even divisors up to 30. Clock polarity and clock phase are held in the configuration register and give the four usual SPI modes. Software drives the chip-select lines directly through control bits. The transfer engine does not touch them. A self-clearing flush bit clears the receive byte.

Register reads are combinational: read data follows the address in the same cycle. Writes take effect at the clock edge where `req_i` and `we_i` are both high.

Top module: `spi_poll_master`

## Requirements
- R1: After reset the control register reads 0x0000_0002 (only the ready bit, bit 1, is set). The configuration, transmit and receive registers read 0. All `cs_no` lines are high and `sclk_o` is low.
- R2: Word offsets are control 0x0, configuration 0x4, transmit 0x8 and receive 0xC. Control bit 16+n holds chip-select n (n = 0..4) and reads back as written. While that bit is set, `cs_no[n]` is driven low. Configuration bits 4:0, 6 and 7 read back as written.
- R3: The divisor D comes from prescaler code c (configuration bits 4:0). If c[4] = 0, D = c[3:0]. If c[4] = 1, D = 2*c[3:0]. A result of 0 is raised to 1. Every SCLK edge is D system clocks after the previous edge, and the first edge is D clocks after the transmit write. The 16th and last edge therefore falls exactly 16*D clocks after the write.
- R4: Control bit 1 (ready) reads 0 from the cycle after an accepted transmit write until the last SCLK edge. It reads 1 again in the same cycle as that edge.
- R5: In all four modes the byte written to bits 7:0 of the transmit register appears on `mosi_o` MSB first. It is stable on each of the eight sampling edges.
- R6: When ready is 1 again, the receive register returns in bits 7:0 the eight MISO bits sampled at the sampling edges, first bit in bit 7. Bits 31:8 read 0.
- R7: While idle, `sclk_o` equals configuration bit 7 (polarity). Configuration bit 6 (phase) selects the sampling edge. With phase 0, data is sampled on leading edges and changed on trailing edges. With phase 1, it is changed on leading edges and sampled on trailing edges.
- R8: Writing configuration bit 9 (flush) sets it. It reads 1 in the next cycle and 0 one cycle later, and by then the receive register reads 0.
- R9: Configuration bits 5 and 17 read 0 even after a write of 1. The block always runs one byte per transfer with no FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable, qualified by req_i |
| addr_i | input | ADDR_W (4) | Byte address, bits 3:2 select the register |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Combinational read data for addr_i |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | NUM_CS (5) | Chip-select lines, active low |

## Verification
The bench builds the block with its default parameters: four address bits, five chip-selects, 8-bit transfers and a five-bit prescaler code. With a code that small, the bench can sweep every one of the 32 prescaler codes in each of the four clock modes, up to the divide-by-30 setting. In each run it checks the edge timing, the MOSI bit order, the received byte and the idle clock level. An SPI slave model in the bench follows the phase setting, and each chip-select line is exercised on its own and all together.

// File: rtl/spi_pm_pkg.sv
package spi_pm_pkg;
  localparam int unsigned PRESC_W   = 5;
  localparam int unsigned REG_CTRL  = 0;
  localparam int unsigned REG_CFG   = 1;
  localparam int unsigned REG_TXD   = 2;
  localparam int unsigned REG_RXD   = 3;
  localparam int unsigned CTRL_RDY  = 1;
  localparam int unsigned CTRL_CS0  = 16;
  localparam int unsigned CFG_PHA   = 6;
  localparam int unsigned CFG_POL   = 7;
  localparam int unsigned CFG_FLUSH = 9;

  // top code bit selects doubled (even) divisors; zero saturates to 1
  function automatic logic [PRESC_W-1:0] presc_div(input logic [PRESC_W-1:0] code);
    logic [PRESC_W-1:0] d;
    if (code[PRESC_W-1]) d = {code[PRESC_W-2:0], 1'b0};
    else                 d = {1'b0, code[PRESC_W-2:0]};
    if (d == '0) d = PRESC_W'(1);
    return d;
  endfunction
endpackage

// File: rtl/spi_pm_tick.sv
module spi_pm_tick
  import spi_pm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PRESC_W-1:0] code_i,
  output logic               tick_o
);
  logic [PRESC_W-1:0] div, cnt_q;

  assign div    = presc_div(code_i);
  assign tick_o = en_i && (cnt_q >= div - PRESC_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + PRESC_W'(1);
  end

  a_r3_count_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
endmodule

// File: rtl/spi_pm_shift.sv
module spi_pm_shift #(
  parameter int unsigned XFER_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [XFER_W-1:0] tx_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              tick_i,
  input  logic              flush_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [XFER_W-1:0] rx_o
);
  localparam int unsigned EDGES = 2 * XFER_W;
  localparam int unsigned EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

  logic [EW-1:0]     edg_q;
  logic              busy_q, ph_q;
  logic [XFER_W-1:0] sr_q, rx_q;
  logic              step, sample, shift;

  assign step   = busy_q && tick_i;
  // phase 0 samples on even (leading) edges, phase 1 on odd (trailing) edges
  assign sample = step && (edg_q[0] == cpha_i);
  assign shift  = step && (edg_q[0] != cpha_i) && (edg_q != '0) && (edg_q != LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      edg_q  <= '0;
      sr_q   <= '0;
    end else if (!busy_q && start_i) begin
      busy_q <= 1'b1;
      ph_q   <= 1'b0;
      edg_q  <= '0;
      sr_q   <= tx_i;
    end else if (step) begin
      ph_q <= ~ph_q;
      if (edg_q == LAST) begin
        busy_q <= 1'b0;
        edg_q  <= '0;
      end else begin
        edg_q <= edg_q + EW'(1);
      end
      if (shift) sr_q <= {sr_q[XFER_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rx_q <= '0;
    else if (flush_i) rx_q <= '0;
    else if (sample)  rx_q <= {rx_q[XFER_W-2:0], miso_i};
  end

  assign busy_o = busy_q;
  assign sclk_o = ph_q ^ cpol_i;
  assign mosi_o = sr_q[XFER_W-1];
  assign rx_o   = rx_q;

  a_r4_busy_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(start_i));
  a_r4_start_accepted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> busy_q);
  a_r7_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> sclk_o == cpol_i);
endmodule

// File: rtl/spi_pm_regs.sv
module spi_pm_regs
  import spi_pm_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_CS = 5,
  parameter int unsigned XFER_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic               busy_i,
  input  logic [XFER_W-1:0]  rx_i,
  output logic               start_o,
  output logic [XFER_W-1:0]  tx_o,
  output logic               cpol_o,
  output logic               cpha_o,
  output logic [PRESC_W-1:0] code_o,
  output logic               flush_o,
  output logic [NUM_CS-1:0]  cs_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]   idx;
  logic               wr, wr_ctrl, wr_cfg;
  logic [NUM_CS-1:0]  cs_q;
  logic [PRESC_W-1:0] code_q;
  logic               pol_q, pha_q, flush_q;
  logic               unused_bits;

  assign idx     = addr_i[ADDR_W-1:2];
  assign wr      = req_i && we_i;
  assign wr_ctrl = wr && (idx == IDX_W'(REG_CTRL));
  assign wr_cfg  = wr && (idx == IDX_W'(REG_CFG));
  assign start_o = wr && (idx == IDX_W'(REG_TXD)) && !busy_i;
  assign tx_o    = wdata_i[XFER_W-1:0];
  assign unused_bits = ^{addr_i[1:0], wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q    <= '0;
      code_q  <= '0;
      pol_q   <= 1'b0;
      pha_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      if (wr_ctrl) cs_q <= wdata_i[CTRL_CS0 +: NUM_CS];
      if (wr_cfg) begin
        code_q  <= wdata_i[PRESC_W-1:0];
        pha_q   <= wdata_i[CFG_PHA];
        pol_q   <= wdata_i[CFG_POL];
        flush_q <= wdata_i[CFG_FLUSH];
      end else begin
        flush_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (idx)
      IDX_W'(REG_CTRL): begin
        rdata_o[CTRL_RDY]            = !busy_i;
        rdata_o[CTRL_CS0 +: NUM_CS]  = cs_q;
      end
      IDX_W'(REG_CFG): begin
        rdata_o[PRESC_W-1:0] = code_q;
        rdata_o[CFG_PHA]     = pha_q;
        rdata_o[CFG_POL]     = pol_q;
        rdata_o[CFG_FLUSH]   = flush_q;
      end
      IDX_W'(REG_RXD): rdata_o[XFER_W-1:0] = rx_i;
      default: rdata_o = '0;
    endcase
  end

  assign cpol_o  = pol_q;
  assign cpha_o  = pha_q;
  assign code_o  = code_q;
  assign flush_o = flush_q;
  assign cs_o    = cs_q;

  a_r8_flush_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_q && !wr_cfg) |=> !flush_q);
  a_r8_flush_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cfg && wdata_i[CFG_FLUSH]) |=> flush_q);
endmodule

// File: rtl/spi_poll_master.sv
module spi_poll_master
  import spi_pm_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_CS = 5,
  parameter int unsigned XFER_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_no
);
  logic               busy, start, cpol, cpha, flush, tick;
  logic [XFER_W-1:0]  tx, rx;
  logic [PRESC_W-1:0] code;
  logic [NUM_CS-1:0]  cs;

  spi_pm_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS), .XFER_W(XFER_W)
  ) i_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .busy_i(busy), .rx_i(rx), .start_o(start), .tx_o(tx),
    .cpol_o(cpol), .cpha_o(cpha), .code_o(code), .flush_o(flush), .cs_o(cs)
  );

  spi_pm_tick i_tick (
    .clk_i, .rst_ni, .en_i(busy), .code_i(code), .tick_o(tick)
  );

  spi_pm_shift #(.XFER_W(XFER_W)) i_shift (
    .clk_i, .rst_ni, .start_i(start), .tx_i(tx), .cpol_i(cpol), .cpha_i(cpha),
    .tick_i(tick), .flush_i(flush), .miso_i, .busy_o(busy),
    .sclk_o, .mosi_o, .rx_o(rx)
  );

  assign cs_no = ~cs;
endmodule

// File: tb/test_spi_poll_master.sv
module test_spi_poll_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, miso = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sclk, mosi;
  logic [4:0]  cs_n;
  int          cyc = 0;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_poll_master i_spi_poll_master (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic int div_of(input logic [4:0] c);
    int d;
    d = c[4] ? 2 * int'(c[3:0]) : int'(c[3:0]);
    return (d == 0) ? 1 : d;
  endfunction

  task automatic xfer(input logic [7:0] tx, input logic [7:0] slv, input logic pha,
                      input logic pol, input int d);
    logic [31:0] r;
    logic [7:0]  got;
    int          cw;
    got  = '0;
    miso = slv[7];
    wr(4'h8, {24'hFFFFFF, tx});
    cw = cyc;
    rd(4'h0, r);
    chk("R4 ready low after write", {31'b0, r[1]}, 32'h0);
    for (int e = 0; e < 16; e++) begin
      @(sclk);
      if (e[0] == pha) got = {got[6:0], mosi};
      else if (e != 0 && e != 15) miso = slv[7 - ((e + 1) / 2)];
    end
    #1;
    chk("R3 last edge timing", 32'(cyc - cw), 32'(16 * d));
    rd(4'h0, r);
    chk("R4 ready high at end", {31'b0, r[1]}, 32'h1);
    chk("R5 mosi byte", {24'b0, got}, {24'b0, tx});
    rd(4'hC, r);
    chk("R6 received byte", r, {24'b0, slv});
    chk("R7 idle level after xfer", {31'b0, sclk}, {31'b0, pol});
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(4'h0, r); chk("R1 ctrl reset", r, 32'h2);
    rd(4'h4, r); chk("R1 cfg reset", r, 32'h0);
    rd(4'h8, r); chk("R1 txd reset", r, 32'h0);
    rd(4'hC, r); chk("R1 rxd reset", r, 32'h0);
    chk("R1 cs idle", {27'b0, cs_n}, 32'h1F);
    chk("R1 sclk idle", {31'b0, sclk}, 32'h0);

    for (int n = 0; n < 5; n++) begin
      wr(4'h0, 32'h1 << (16 + n));
      chk("R2 cs line", {27'b0, cs_n}, {27'b0, ~(5'h1 << n)});
      rd(4'h0, r); chk("R2 ctrl readback", r, (32'h1 << (16 + n)) | 32'h2);
    end
    wr(4'h0, 32'h001F_0002);
    chk("R2 all cs", {27'b0, cs_n}, 32'h0);
    wr(4'h0, 32'h0);
    chk("R2 cs released", {27'b0, cs_n}, 32'h1F);

    wr(4'h4, (32'h1 << 5) | (32'h1 << 17));
    rd(4'h4, r); chk("R9 len/fifo bits read 0", r, 32'h0);

    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 32; c++) begin
        logic pha, pol;
        logic [7:0] tx, slv;
        pha = m[0]; pol = m[1];
        wr(4'h4, 32'(c) | (32'(pha) << 6) | (32'(pol) << 7));
        rd(4'h4, r);
        chk("R2 cfg readback", r, 32'(c) | (32'(pha) << 6) | (32'(pol) << 7));
        chk("R7 idle level", {31'b0, sclk}, {31'b0, pol});
        tx  = 8'(8'h3C ^ (c * 11) ^ (m << 6));
        slv = 8'(~tx + 8'(c));
        xfer(tx, slv, pha, pol, div_of(5'(c)));
      end
    end

    wr(4'h4, 32'h3);
    xfer(8'h81, 8'hA5, 1'b0, 1'b0, 3);
    wr(4'h4, 32'h200);
    rd(4'h4, r); chk("R8 flush set", r, 32'h200);
    @(negedge clk);
    rd(4'h4, r); chk("R8 flush self clear", r, 32'h0);
    rd(4'hC, r); chk("R8 rx cleared", r, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule